// File: doc/BRIEF.md
# Way-Masked Cache Replacement Unit

This block chooses the victim way for an N-way set-associative cache in which software may reserve ways for particular data. Each miss arrives with its set index, the valid bits of that set's ways, and an allowed-ways vector with one bit per way. The victim is taken only from ways whose bit is set. Lookup and hit detection live outside the block and still search every way, so a line left in a way that is no longer allowed keeps hitting until it is replaced. Nothing here moves or invalidates data when the vector changes. The vector is sampled per miss and may differ on every request.

The choice is deferred until the fill data returns. This can be several cycles after the miss, so the selection sits off the lookup path. While the miss is outstanding the block keeps tracking hits. On the fill strobe it reports the chosen way through a one-cycle valid pulse. Each set holds a round-robin pointer that every hit and every fill moves, whether or not the touched way is currently allowed. An all-zero allowed vector marks the access as uncacheable: no miss is opened and an error pulse is raised.

Top module: `way_victim_sel`

## Requirements
- R1: After reset `missBusy`, `victimValid` and `maskError` are 0, and every set's pointer is way 0.
- R2: A `missValid` seen while `missBusy` is 0 and `missMask` is nonzero sets `missBusy` in the next cycle and captures set, mask and valid bits. A `missValid` seen while `missBusy` is 1 has no effect on the victim that is reported.
- R3: A `missValid` seen while idle with `missMask` all zero raises `maskError` for exactly one cycle in the next cycle, leaves `missBusy` at 0 and produces no victim.
- R4: A `fillStrobe` seen while `missBusy` is 1 raises `victimValid` for one cycle in the next cycle, with `victimWay` valid, and clears `missBusy` in that same cycle. A `fillStrobe` seen while idle produces no victim and leaves the pointers unchanged.
- R5: `victimWay` is always a way whose bit was set in the captured mask (bit i of the mask is way i).
- R6: If any allowed way has its captured valid bit at 0, the victim is the lowest-numbered such way.
- R7: If every allowed way is valid, the victim is the first allowed way found by stepping upward from the set's pointer, wrapping from way N-1 to way 0. The pointer is read in the cycle of the fill strobe, so hits during the pending miss count.
- R8: A hit or fill to way w of a set sets that set's pointer to w+1, and to 0 when w is N-1. This holds whether or not way w is in any mask.
- R9: When a hit and a fill update the same set in the same cycle, the fill's update wins. When they update different sets, both updates apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss request strobe |
| missSet | input | SETW | Set index of the miss |
| missMask | input | NUM_WAYS | Allowed ways, bit i is way i |
| missValidBits | input | NUM_WAYS | Valid bits of the set's ways |
| missBusy | output | 1 | A miss is outstanding |
| fillStrobe | input | 1 | Fill data has returned |
| hitValid | input | 1 | A hit occurred in the cache |
| hitSet | input | SETW | Set index of the hit |
| hitWay | input | WAYW | Way that hit |
| victimValid | output | 1 | One-cycle pulse, victimWay valid |
| victimWay | output | WAYW | Selected way to be filled |
| maskError | output | 1 | One-cycle pulse for an all-zero mask |

## Verification
A hit can arrive in the same cycle as the fill strobe, and both want to move a set's pointer. The bench drives a random hit alongside about half of the fill strobes. Half of those aim at the fill's own set. The stimulus uses few sets so that collisions are frequent. A reference model applies the hit first and the fill second, and the following victims, read from the pointer, show whether the fill's update won or both updates landed on different sets.

// File: rtl/way_victim_pkg.sv
package way_victim_pkg;
  // Strobes from control to datapath, all for the current cycle.
  typedef struct packed {
    logic captureMiss; // latch set, mask and valid bits of a new miss
    logic fillNow;     // fill returned for the pending miss
    logic flagError;   // miss arrived with an empty mask
  } ctrlStrobes_t;
endpackage

// File: rtl/way_victim_ctrl.sv
module way_victim_ctrl
  import way_victim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         missValid,
  input  logic         missMaskAny,
  input  logic         fillStrobe,
  output ctrlStrobes_t strb,
  output logic         missBusy,
  output logic         victimValid,
  output logic         maskError
);
  logic pending;

  always_comb begin
    strb.captureMiss = missValid && !pending && missMaskAny;
    strb.flagError   = missValid && !pending && !missMaskAny;
    strb.fillNow     = fillStrobe && pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      victimValid <= 1'b0;
      maskError   <= 1'b0;
    end else begin
      if (strb.captureMiss)  pending <= 1'b1;
      else if (strb.fillNow) pending <= 1'b0;
      victimValid <= strb.fillNow;
      maskError   <= strb.flagError;
    end
  end

  assign missBusy = pending;
endmodule

// File: rtl/way_victim_dp.sv
module way_victim_dp
  import way_victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAYW = $clog2(NUM_WAYS),
  localparam int SETW = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [SETW-1:0]     missSet,
  input  logic [NUM_WAYS-1:0] missMask,
  input  logic [NUM_WAYS-1:0] missValidBits,
  input  logic                hitValid,
  input  logic [SETW-1:0]     hitSet,
  input  logic [WAYW-1:0]     hitWay,
  output logic [WAYW-1:0]     victimWay
);
  logic [SETW-1:0]     curSet;
  logic [NUM_WAYS-1:0] curMask;
  logic [NUM_WAYS-1:0] curValid;
  logic [WAYW-1:0]     rrPtr [NUM_SETS];
  logic [WAYW-1:0]     pick;

  function automatic logic [WAYW-1:0] stepWay(input logic [WAYW-1:0] w);
    return (int'(w) == NUM_WAYS - 1) ? '0 : w + 1'b1;
  endfunction

  // Invalid allowed way first (lowest index), else rotate from pointer.
  function automatic logic [WAYW-1:0] chooseWay(
    input logic [NUM_WAYS-1:0] allow,
    input logic [NUM_WAYS-1:0] vld,
    input logic [WAYW-1:0]     start
  );
    logic [WAYW-1:0] res;
    logic hit;
    int pos;
    res = '0;
    hit = 1'b0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      if (!hit && allow[k] && !vld[k]) begin
        res = WAYW'(k);
        hit = 1'b1;
      end
    end
    for (int k = 0; k < NUM_WAYS; k++) begin
      pos = int'(start) + k;
      if (pos >= NUM_WAYS) pos = pos - NUM_WAYS;
      if (!hit && allow[pos]) begin
        res = WAYW'(pos);
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb pick = chooseWay(curMask, curValid, rrPtr[curSet]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSet    <= '0;
      curMask   <= '0;
      curValid  <= '0;
      victimWay <= '0;
    end else begin
      if (strb.captureMiss) begin
        curSet   <= missSet;
        curMask  <= missMask;
        curValid <= missValidBits;
      end
      if (strb.fillNow) victimWay <= pick;
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)
        rrPtr[s] <= '0;
      else if (strb.fillNow && curSet == SETW'(s))
        rrPtr[s] <= stepWay(pick);
      else if (hitValid && hitSet == SETW'(s))
        rrPtr[s] <= stepWay(hitWay);
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import way_victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAYW = $clog2(NUM_WAYS),
  localparam int SETW = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                missValid,
  input  logic [SETW-1:0]     missSet,
  input  logic [NUM_WAYS-1:0] missMask,
  input  logic [NUM_WAYS-1:0] missValidBits,
  output logic                missBusy,
  input  logic                fillStrobe,
  input  logic                hitValid,
  input  logic [SETW-1:0]     hitSet,
  input  logic [WAYW-1:0]     hitWay,
  output logic                victimValid,
  output logic [WAYW-1:0]     victimWay,
  output logic                maskError
);
  ctrlStrobes_t strb;

  way_victim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .missValid(missValid),
    .missMaskAny(|missMask), .fillStrobe(fillStrobe), .strb(strb),
    .missBusy(missBusy), .victimValid(victimValid), .maskError(maskError)
  );

  way_victim_dp #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .missSet(missSet),
    .missMask(missMask), .missValidBits(missValidBits),
    .hitValid(hitValid), .hitSet(hitSet), .hitWay(hitWay),
    .victimWay(victimWay)
  );
endmodule

// File: rtl/way_victim_chk.sv
module way_victim_chk #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAYW = $clog2(NUM_WAYS),
  localparam int SETW = $clog2(NUM_SETS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                missValid,
  input logic [NUM_WAYS-1:0] missMask,
  input logic [NUM_WAYS-1:0] missValidBits,
  input logic                missBusy,
  input logic                fillStrobe,
  input logic                victimValid,
  input logic [WAYW-1:0]     victimWay,
  input logic                maskError
);
  logic [NUM_WAYS-1:0] ckMask;
  logic [NUM_WAYS-1:0] ckValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckMask  <= '0;
      ckValid <= '0;
    end else if (missValid && !missBusy && (|missMask)) begin
      ckMask  <= missMask;
      ckValid <= missValidBits;
    end
  end

  // R2
  accept_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    missValid && !missBusy && (|missMask) |=> missBusy);

  // R3
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    missValid && !missBusy && (missMask == '0) |=> maskError && !missBusy && !victimValid);

  // R4
  fill_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillStrobe && missBusy |=> victimValid && !missBusy);

  // R4
  victim_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> $past(fillStrobe && missBusy));

  // R5
  victim_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> ckMask[victimWay]);

  // R6
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid && (|(ckMask & ~ckValid)) |-> !ckValid[victimWay]);
endmodule

bind way_victim_sel way_victim_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (.*);

// File: tb/way_victim_sel_bench.sv
`timescale 1ns/100ps
module way_victim_sel_bench;
  localparam int NW = 4;
  localparam int NS = 16;
  localparam int WW = $clog2(NW);
  localparam int SW = $clog2(NS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [SW-1:0] missSet = '0;
  logic [NW-1:0] missMask = '0;
  logic [NW-1:0] missValidBits = '0;
  logic missBusy;
  logic fillStrobe = 1'b0;
  logic hitValid = 1'b0;
  logic [SW-1:0] hitSet = '0;
  logic [WW-1:0] hitWay = '0;
  logic victimValid;
  logic [WW-1:0] victimWay;
  logic maskError;

  int vecs = 0;
  int errs = 0;
  int refPtr [NS];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  way_victim_sel u_way_victim_sel (.*);

  task automatic check(input int got, input int exp, input string tag);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int modelNext(input int w);
    return (w + 1) % NW;
  endfunction

  function automatic int modelVictim(input int mask, input int vld, input int ptr);
    for (int w = 0; w < NW; w++)
      if (mask[w] && !vld[w]) return w;
    for (int s = 0; s < NW; s++)
      if (mask[(ptr + s) % NW]) return (ptr + s) % NW;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Issue a miss; returns 1 if a miss is now open.
  task automatic doMiss(input int s, input int m, input int v, output bit opened);
    missValid = 1'b1; missSet = SW'(s); missMask = NW'(m); missValidBits = NW'(v);
    tick();
    missValid = 1'b0;
    if (m == 0) begin
      check(maskError, 1, "R3 maskError");
      check(missBusy, 0, "R3 busy");
      check(victimValid, 0, "R3 no victim");
      tick();
      check(maskError, 0, "R3 pulse width");
      opened = 1'b0;
    end else begin
      check(missBusy, 1, "R2 busy");
      opened = 1'b1;
    end
  endtask

  task automatic doHit(input int s, input int w);
    hitValid = 1'b1; hitSet = SW'(s); hitWay = WW'(w);
    tick();
    hitValid = 1'b0;
    refPtr[s] = modelNext(w);
  endtask

  task automatic doFill(input int s, input int m, input int v,
                        input bit withHit, input int hs, input int hw);
    int exp;
    exp = modelVictim(m, v, refPtr[s]);
    fillStrobe = 1'b1;
    hitValid = withHit; hitSet = SW'(hs); hitWay = WW'(hw);
    tick();
    fillStrobe = 1'b0; hitValid = 1'b0;
    if (withHit) refPtr[hs] = modelNext(hw);
    refPtr[s] = modelNext(exp);
    check(victimValid, 1, "R4 victimValid");
    check(int'(victimWay), exp, withHit ? "R9 R7 victimWay" : "R6 R7 victimWay");
    check(int'(m[victimWay]), 1, "R5 allowed");
    check(missBusy, 0, "R4 busy cleared");
    tick();
    check(victimValid, 0, "R4 pulse width");
  endtask

  initial begin
    #900000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog got=0 exp=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    bit op;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NS; i++) refPtr[i] = 0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check(missBusy, 0, "R1 busy");
    check(victimValid, 0, "R1 victimValid");
    check(maskError, 0, "R1 maskError");

    // R4: fill while idle is ignored, pointer of set 0 stays 0.
    fillStrobe = 1'b1; tick(); fillStrobe = 1'b0;
    check(victimValid, 0, "R4 idle fill");
    doMiss(0, 4'b1111, 4'b1111, op);
    doFill(0, 4'b1111, 4'b1111, 1'b0, 0, 0); // R1 pointer 0 -> way 0

    // R6: lowest allowed invalid way wins.
    doMiss(1, 4'b1010, 4'b0101, op);
    doFill(1, 4'b1010, 4'b0101, 1'b0, 0, 0);

    // R8: hits to a way outside the mask still move the pointer.
    doHit(2, 2);
    doMiss(2, 4'b0110, 4'b1111, op);
    doFill(2, 4'b0110, 4'b1111, 1'b0, 0, 0); // ptr 3 -> wraps to way 1
    doHit(2, 0);
    doMiss(2, 4'b1100, 4'b1111, op);
    doFill(2, 4'b1100, 4'b1111, 1'b0, 0, 0); // ptr 1 -> way 2

    // R2: second miss while busy is ignored.
    doMiss(3, 4'b0001, 4'b1111, op);
    missValid = 1'b1; missSet = 4'd3; missMask = 4'b1000; missValidBits = 4'b0000;
    tick();
    missValid = 1'b0;
    check(missBusy, 1, "R2 still busy");
    doFill(3, 4'b0001, 4'b1111, 1'b0, 0, 0);

    // R3: empty mask.
    doMiss(4, 0, 4'b0000, op);

    // R9: hit and fill to the same set in one cycle.
    doMiss(5, 4'b1111, 4'b1111, op);
    doFill(5, 4'b1111, 4'b1111, 1'b1, 5, 2);
    doMiss(5, 4'b1111, 4'b1111, op);
    doFill(5, 4'b1111, 4'b1111, 1'b0, 0, 0);

    for (int t = 0; t < 400; t++) begin
      int s, m, v, nw;
      s = $urandom_range(0, 3);
      m = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 15);
      v = ($urandom_range(0, 1) == 0) ? 15 : $urandom_range(0, 15);
      doMiss(s, m, v, op);
      if (!op) continue;
      nw = $urandom_range(2, 5);
      for (int c = 0; c < nw; c++) begin
        if ($urandom_range(0, 1) == 1)
          doHit($urandom_range(0, 3), $urandom_range(0, NW - 1));
        else
          tick();
      end
      if ($urandom_range(0, 1) == 1)
        doFill(s, m, v, 1'b1, ($urandom_range(0, 1) == 1) ? s : $urandom_range(0, 3),
               $urandom_range(0, NW - 1));
      else
        doFill(s, m, v, 1'b0, 0, 0);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule